// File: doc/BRIEF.md
# Host Command Frame Parser

This block sits behind a byte-wide host link and turns the incoming stream into fixed five-byte commands. Each command carries one opcode byte and then a 32-bit argument sent most significant byte first. Two opcodes are understood. One loads a tuning frequency register. The other loads a sample-rate register and also asks for the tuning to be recomputed. Every register load is announced by a one-cycle update strobe. A downstream block computes the oscillator table and the timer divider from these values.

The parser also tracks whether a stream is running. While no stream is running, the first completed command starts one. When a stream starts, the parser sends a fixed twelve-byte identification header, one byte per cycle. A zero byte that arrives where a new command would begin is not taken as an opcode. It is a stop request, and the block returns to idle. Later commands are parsed as usual, and the next one starts a new stream and a new header.

Top module: `cmd_frame_parser`

## Requirements
- R1: After reset the byte position is at a frame boundary, `streaming` is 0, `hdr_valid` is 0, both strobes are 0, `freq_q` holds `FREQ_DEFAULT` (94600000) and `rate_q` holds `RATE_DEFAULT` (100000).
- R2: A frame is five accepted bytes: the opcode first, then the argument most significant byte first. With opcode 0x01, `freq_q` takes the argument and `tune_upd` is 1 in the cycle after the fifth byte is sampled.
- R3: With opcode 0x02, `rate_q` takes the argument and both `rate_upd` and `tune_upd` are 1 in the cycle after the fifth byte. `freq_q` keeps its value.
- R4: A zero byte accepted at a frame boundary is not stored and does not advance the position. A zero byte at positions 1 to 4 is ordinary argument data.
- R5: A stop request makes `streaming` 0 in the next cycle and cancels any header still being sent. No register or strobe changes.
- R6: A completed frame while idle makes `streaming` 1 in the next cycle. From that same cycle, `hdr_valid` is 1 for exactly 12 consecutive cycles. The bytes are 0x52 0x54 0x4C 0x30, then 0x00 0x00 0x00 0x05, then 0x00 0x00 0x00 0x1D.
- R7: Frames completed while streaming update the registers but send no header.
- R8: Any other nonzero opcode completes its frame without changing `freq_q` or `rate_q` and without a strobe. While idle, such a frame still starts streaming.
- R9: Cycles with `in_valid` low neither advance nor disturb frame assembly, so the bytes of a frame may arrive with any spacing.
- R10: Each update strobe is high for only one cycle per completed frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | `in_byte` carries a byte this cycle |
| in_byte | input | 8 | Incoming host byte |
| freq_q | output | 32 | Tuning frequency register |
| tune_upd | output | 1 | One-cycle pulse: recompute tuning |
| rate_q | output | 32 | Sample-rate register |
| rate_upd | output | 1 | One-cycle pulse: sample rate loaded |
| streaming | output | 1 | Stream is running |
| hdr_valid | output | 1 | `hdr_byte` carries a header byte |
| hdr_byte | output | 8 | Identification header byte |

## Verification
The hardest case to reach from the ports is a stop request that arrives while the header is still being sent. The stop byte must land exactly at a frame boundary, in the few cycles right after the command that started the stream. A directed sequence completes a frame from idle, checks the first header byte, and then sends the zero byte on the very next cycle. It then confirms that the header stops early and that a new stream sends the full header again. Random frames use mixed opcodes, arguments and spacing between bytes, with stops placed at frame boundaries. Argument bytes of zero show that a zero inside a frame is taken as data.

// File: rtl/cmdp_pkg.sv
package cmdp_pkg;

    localparam int ARG_BYTES   = 4;
    localparam int FRAME_BYTES = 1 + ARG_BYTES;
    localparam int HDR_BYTES   = 12;
    localparam int HDR_IDX_W   = $clog2(HDR_BYTES);

    localparam logic [7:0] OPC_TUNE = 8'h01;
    localparam logic [7:0] OPC_RATE = 8'h02;
    localparam logic [7:0] STOP_BYTE = 8'h00;

    typedef struct packed {
        logic [7:0]             op;
        logic [8*ARG_BYTES-1:0] arg;
    } frame_t;

    typedef enum logic {
        MODE_IDLE   = 1'b0,
        MODE_STREAM = 1'b1
    } mode_e;

    // Identification header: magic tag, then two big-endian words.
    function automatic logic [7:0] hdr_byte_at(input logic [HDR_IDX_W-1:0] idx);
        logic [31:0] word;
        case (idx / 4)
            0:       word = 32'h5254_4C30;
            1:       word = 32'd5;
            default: word = 32'd29;
        endcase
        hdr_byte_at = word[8*(3 - (idx % 4)) +: 8];
    endfunction

endpackage

// File: rtl/cmdp_frame_asm.sv
module cmdp_frame_asm
    import cmdp_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   in_valid,
    input  logic [7:0] in_byte,
    output logic   stop_req,
    output logic   frame_done,
    output frame_t frame
);
    localparam int POS_W   = $clog2(FRAME_BYTES);
    localparam int LAST    = FRAME_BYTES - 1;
    localparam int STORE_W = 8 * (FRAME_BYTES - 1);

    logic [POS_W-1:0]   pos;
    logic [STORE_W-1:0] held;
    logic               take;

    assign stop_req   = in_valid && (pos == '0) && (in_byte == STOP_BYTE);
    assign take       = in_valid && !stop_req;
    assign frame_done = take && (pos == POS_W'(LAST));
    assign frame      = frame_t'({held, in_byte});

    always_ff @(posedge clk) begin
        if (rst) begin
            pos  <= '0;
            held <= '0;
        end else if (take) begin
            held <= {held[STORE_W-9:0], in_byte};
            pos  <= (pos == POS_W'(LAST)) ? '0 : pos + 1'b1;
        end
    end

    AST_POS_RANGE: assert property (@(posedge clk) disable iff (rst)
        pos <= POS_W'(LAST)); // R2
    AST_STOP_NOT_STORED: assert property (@(posedge clk) disable iff (rst)
        stop_req |=> (pos == '0)); // R4
    AST_IDLE_HOLDS_POS: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> $stable(pos)); // R9

endmodule

// File: rtl/cmdp_hdr_gen.sv
module cmdp_hdr_gen
    import cmdp_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       start,
    input  logic       abort,
    output logic       hdr_valid,
    output logic [7:0] hdr_byte
);
    logic                 busy;
    logic [HDR_IDX_W-1:0] idx;

    always_ff @(posedge clk) begin
        if (rst || abort) begin
            busy <= 1'b0;
            idx  <= '0;
        end else if (start) begin
            busy <= 1'b1;
            idx  <= '0;
        end else if (busy) begin
            busy <= (idx != HDR_IDX_W'(HDR_BYTES - 1));
            idx  <= idx + 1'b1;
        end
    end

    assign hdr_valid = busy;
    assign hdr_byte  = busy ? hdr_byte_at(idx) : 8'h00;

    AST_HDR_IDX_RANGE: assert property (@(posedge clk) disable iff (rst)
        busy |-> (idx < HDR_IDX_W'(HDR_BYTES))); // R6
    AST_HDR_STARTS_AT_ZERO: assert property (@(posedge clk) disable iff (rst)
        (start && !abort) |=> (busy && idx == '0)); // R6

endmodule

// File: rtl/cmd_frame_parser.sv
module cmd_frame_parser
    import cmdp_pkg::*;
#(
    parameter logic [31:0] FREQ_DEFAULT = 32'd94_600_000,
    parameter logic [31:0] RATE_DEFAULT = 32'd100_000
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        in_valid,
    input  logic [7:0]  in_byte,
    output logic [31:0] freq_q,
    output logic        tune_upd,
    output logic [31:0] rate_q,
    output logic        rate_upd,
    output logic        streaming,
    output logic        hdr_valid,
    output logic [7:0]  hdr_byte
);
    logic   stop_req;
    logic   frame_done;
    frame_t frame;
    mode_e  mode;
    logic   hdr_start;

    cmdp_frame_asm u_asm (
        .clk        (clk),
        .rst        (rst),
        .in_valid   (in_valid),
        .in_byte    (in_byte),
        .stop_req   (stop_req),
        .frame_done (frame_done),
        .frame      (frame)
    );

    assign hdr_start = frame_done && (mode == MODE_IDLE);

    always_ff @(posedge clk) begin
        if (rst) begin
            mode     <= MODE_IDLE;
            freq_q   <= FREQ_DEFAULT;
            rate_q   <= RATE_DEFAULT;
            tune_upd <= 1'b0;
            rate_upd <= 1'b0;
        end else begin
            tune_upd <= 1'b0;
            rate_upd <= 1'b0;
            if (stop_req) begin
                mode <= MODE_IDLE;
            end else if (frame_done) begin
                mode <= MODE_STREAM;
                if (frame.op == OPC_TUNE) begin
                    freq_q   <= frame.arg;
                    tune_upd <= 1'b1;
                end else if (frame.op == OPC_RATE) begin
                    rate_q   <= frame.arg;
                    rate_upd <= 1'b1;
                    tune_upd <= 1'b1;
                end
            end
        end
    end

    assign streaming = (mode == MODE_STREAM);

    cmdp_hdr_gen u_hdr (
        .clk       (clk),
        .rst       (rst),
        .start     (hdr_start),
        .abort     (stop_req),
        .hdr_valid (hdr_valid),
        .hdr_byte  (hdr_byte)
    );

    AST_HDR_NEEDS_STREAM: assert property (@(posedge clk) disable iff (rst)
        hdr_valid |-> streaming); // R6
    AST_RATE_RETUNES: assert property (@(posedge clk) disable iff (rst)
        rate_upd |-> tune_upd); // R3
    AST_STOP_TO_IDLE: assert property (@(posedge clk) disable iff (rst)
        stop_req |=> (!streaming && !hdr_valid)); // R5
    AST_FREQ_HOLD: assert property (@(posedge clk) disable iff (rst)
        !tune_upd |-> $stable(freq_q)); // R8
    AST_RATE_HOLD: assert property (@(posedge clk) disable iff (rst)
        !rate_upd |-> $stable(rate_q)); // R8
    AST_STROBE_SINGLE: assert property (@(posedge clk) disable iff (rst)
        tune_upd |=> !tune_upd); // R10

endmodule

// File: tb/cmd_frame_parser_tb.sv
`timescale 1ns/1ps
module cmd_frame_parser_tb;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic [7:0]  in_byte = 8'h00;
    logic [31:0] freq_q, rate_q;
    logic        tune_upd, rate_upd, streaming, hdr_valid;
    logic [7:0]  hdr_byte;

    int n_chk = 0;
    int n_fail = 0;
    logic [31:0] exp_freq = 32'd94_600_000;
    logic [31:0] exp_rate = 32'd100_000;
    bit          exp_stream = 1'b0;

    always #2 clk = ~clk;

    cmd_frame_parser u_dut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_byte(in_byte),
        .freq_q(freq_q), .tune_upd(tune_upd), .rate_q(rate_q), .rate_upd(rate_upd),
        .streaming(streaming), .hdr_valid(hdr_valid), .hdr_byte(hdr_byte)
    );

    function automatic logic [7:0] exp_hdr(input int i);
        logic [31:0] w;
        string tag = "RTL0";
        if (i < 4) return tag[i];
        w = (i < 8) ? 32'd5 : 32'd29;
        return w[8*(3 - i % 4) +: 8];
    endfunction

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic drive_byte(input logic [7:0] b, input int gap);
        for (int i = 0; i < gap; i++) @(negedge clk);
        in_valid = 1'b1;
        in_byte  = b;
        @(negedge clk);
        in_valid = 1'b0;
        in_byte  = 8'hA5;
    endtask

    task automatic check_regs(input string req);
        chk(freq_q == exp_freq, {req, " freq_q"}, freq_q, exp_freq);
        chk(rate_q == exp_rate, {req, " rate_q"}, rate_q, exp_rate);
        chk(streaming == exp_stream, {req, " streaming"}, streaming, exp_stream);
    endtask

    task automatic send_frame(input logic [7:0] op, input logic [31:0] arg, input int gap, input bit walk_hdr);
        bit hdr_exp = !exp_stream;
        bit t_exp = (op == 8'h01) || (op == 8'h02);
        bit r_exp = (op == 8'h02);
        drive_byte(op, gap);
        for (int k = 3; k >= 0; k--) drive_byte(arg[8*k +: 8], gap);
        if (op == 8'h01) exp_freq = arg;
        if (op == 8'h02) exp_rate = arg;
        exp_stream = 1'b1;
        check_regs("R2/R3/R8");
        chk(tune_upd == t_exp, "R2/R3/R8 tune_upd", tune_upd, t_exp);
        chk(rate_upd == r_exp, "R3/R8 rate_upd", rate_upd, r_exp);
        chk(hdr_valid == hdr_exp, "R6/R7 hdr_valid", hdr_valid, hdr_exp);
        if (hdr_exp && walk_hdr) begin
            for (int i = 0; i < 12; i++) begin
                chk(hdr_valid && hdr_byte == exp_hdr(i), "R6 header byte", hdr_byte, exp_hdr(i));
                @(negedge clk);
                if (i == 0) begin
                    chk(!tune_upd && !rate_upd, "R10 strobe width", {tune_upd, rate_upd}, 0);
                end
            end
            chk(!hdr_valid, "R6 header length", hdr_valid, 0);
        end else if (hdr_exp) begin
            chk(hdr_byte == exp_hdr(0), "R6 first header byte", hdr_byte, exp_hdr(0));
        end else begin
            @(negedge clk);
            chk(!tune_upd && !rate_upd, "R10 strobe width", {tune_upd, rate_upd}, 0);
            chk(!hdr_valid, "R7 no header", hdr_valid, 0);
        end
    endtask

    task automatic send_stop(input int gap);
        drive_byte(8'h00, gap);
        exp_stream = 1'b0;
        check_regs("R4/R5");
        chk(!hdr_valid, "R5 header cancelled", hdr_valid, 0);
        chk(!tune_upd && !rate_upd, "R5 no strobe", {tune_upd, rate_upd}, 0);
    endtask

    initial begin
        int seed = 32'h1234;
        void'($urandom(seed));
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check_regs("R1");
        chk(!hdr_valid && !tune_upd && !rate_upd, "R1 outputs idle", {hdr_valid, tune_upd, rate_upd}, 0);

        send_frame(8'h01, 32'h05A3_F1C0, 0, 1);      // R2 R6
        send_frame(8'h02, 32'h0003_0D40, 1, 1);      // R3 R7 R9
        send_frame(8'h7E, 32'hDEAD_BEEF, 2, 1);      // R8 while streaming
        send_stop(0);                                 // R5
        send_stop(1);                                 // R4 stop while idle
        send_frame(8'h33, 32'h1111_2222, 0, 1);      // R8 unknown starts stream
        send_stop(0);
        send_frame(8'h01, 32'h0A0B_0C0D, 0, 0);      // header in progress
        send_stop(0);                                 // R5 cancel mid-header
        send_frame(8'h01, 32'h0000_0000, 0, 1);      // R4 zero args are data
        send_frame(8'h02, 32'h0000_0100, 3, 1);

        for (int it = 0; it < 60; it++) begin
            logic [7:0] op;
            case ($urandom % 4)
                0, 2:    op = 8'h01;
                1:       op = 8'h02;
                default: op = 8'h03 + 8'($urandom % 250);
            endcase
            if ($urandom % 5 == 0) send_stop($urandom % 3);
            send_frame(op, $urandom, $urandom % 3, 1);
        end

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        #(4ns * 150000);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule